// File: doc/BRIEF.md
# 8x8 Inverse DCT Accelerator with Register Access

This block is a memory-mapped slave that rebuilds one 8x8 block of image samples from its quantized frequency coefficients. A host writes the 64 signed 16-bit coefficients as 32 packed words and, when needed, a table of 64 quantizer steps. It then starts the operation with a single control write. The block scales each coefficient by its step and runs an 8-point inverse transform, first along rows and then along columns, in fixed point. Each result is rounded, offset by 128 and saturated to an 8-bit sample.

The transform reuses one bank of 64 multipliers. Each pass handles one row or column per cycle, so a block finishes 16 cycles after the start. When it finishes, a status bit goes high. The host then reads the 64 samples back, four per word. Coefficients and quantizer steps stay in place between operations, so a new block only needs the words that changed.

Top module: `idct_accel`

## Requirements
- R1: After reset the status word reads 0, every sample word reads 0, every coefficient is 0 and every quantizer step is 1.
- R2: A write to word address k (0x00..0x1F) stores coefficient 2k from bits 15:0 and coefficient 2k+1 from bits 31:16. Coefficient index is 8*v+u, with v the vertical and u the horizontal frequency.
- R3: A write to word address 0x20+k stores quantizer step 2k from bits 7:0 and step 2k+1 from bits 23:16, both unsigned. Each coefficient is multiplied by the step of the same index before the transform.
- R4: A write to address 0x40 with bit 0 set, while idle, starts an operation. A read of 0x40 returns done in bit 0 and busy in bit 1. From the next cycle busy is 1 and done is 0.
- R5: Done rises 16 clock cycles after the edge that accepts the start. With status reads issued back to back from the cycle after the start, the 17th read is the first to show done.
- R6: Each sample equals the exact 2D inverse DCT of the dequantized block, rounded, plus 128 and saturated to 0..255, within 1 LSB.
- R7: Results below 0 saturate to 0 and results above 255 saturate to 255, with no wrap-around.
- R8: An all-zero block gives 128 in every sample.
- R9: A read of word address 0x60+k returns samples 4k..4k+3, with sample 4k in bits 7:0 and each next sample 8 bits higher. Sample index is 8*y+x in row-major order.
- R10: While busy, writes to coefficient, quantizer and control addresses are ignored. They change neither the timing nor the result of the running operation.
- R11: Read data is registered and appears the cycle after the read strobe. It is 0 in any cycle that follows no read, and 0 for unmapped addresses.
- R12: Done stays 1 and the samples stay readable until the next start. Coefficients and quantizer steps are kept, so a second start without new writes gives the same samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench targets the saturation edges. Large positive and negative DC terms must give exactly 255 and 0; a design that wrapped instead of saturating would show a dark block where a bright one belongs. A single non-zero coefficient placed in the upper half of a word catches swapped half-words and a transposed row/column pass, because either fault moves the pattern to the wrong axis or index. Writes and a second start issued while busy must neither shorten the 16-cycle latency nor change the samples; a design that honoured them would finish late or return a corrupted block. Random blocks with random quantizer steps are compared against a floating-point model within 1 LSB, which exposes bad basis constants, rounding and descale shifts.

// File: rtl/idct_pkg.sv
package idct_pkg;

  localparam int BLK      = 8;
  localparam int BLK_LOG  = 3;
  localparam int COS_FRAC = 13;
  localparam int HALF_W   = 16;

  // cos(k*pi/16) scaled by 2^COS_FRAC, k = 0..8
  function automatic int cos_q(input int k);
    case (k)
      0: return 8192;
      1: return 8035;
      2: return 7568;
      3: return 6811;
      4: return 5793;
      5: return 4551;
      6: return 3135;
      7: return 1598;
      default: return 0;
    endcase
  endfunction

  // scaled basis weight of frequency u at sample position x, including c(0)
  function automatic int basis(input int u, input int x);
    int m;
    bit neg;
    m   = ((2 * x + 1) * u) % 32;
    neg = 1'b0;
    if (m > 16) m = 32 - m;
    if (m > 8) begin
      m   = 16 - m;
      neg = 1'b1;
    end
    if (u == 0) return 5793;
    return neg ? -cos_q(m) : cos_q(m);
  endfunction

endpackage

// File: rtl/idct8_pass.sv
module idct8_pass
  import idct_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 49
) (
  input  logic [BLK-1:0][IN_W-1:0]  din,
  output logic [BLK-1:0][OUT_W-1:0] dout
);

  for (genvar x = 0; x < BLK; x++) begin : g_out
    logic signed [OUT_W-1:0] prod [BLK];
    logic signed [OUT_W-1:0] sum;

    for (genvar u = 0; u < BLK; u++) begin : g_term
      localparam int K = basis(u, x);
      logic signed [OUT_W-1:0] kext;
      assign kext    = OUT_W'(K);
      assign prod[u] = OUT_W'($signed(din[u])) * kext;
    end

    always_comb begin
      sum = '0;
      for (int u = 0; u < BLK; u++) sum = sum + prod[u];
    end

    assign dout[x] = sum;
  end

endmodule

// File: rtl/idct_operand_store.sv
module idct_operand_store
  import idct_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int QUANT_W = 8,
  parameter int DQ_W    = COEF_W + QUANT_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         coef_we,
  input  logic                         quant_we,
  input  logic [2*BLK_LOG-2:0]         word,
  input  logic [31:0]                  wdata,
  input  logic [BLK_LOG-1:0]           row,
  output logic [BLK-1:0][DQ_W-1:0]     row_dq
);

  localparam int CELLS = BLK * BLK;

  logic [COEF_W-1:0]  coef  [CELLS];
  logic [QUANT_W-1:0] quant [CELLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) begin
        coef[i]  <= '0;
        quant[i] <= QUANT_W'(1);
      end
    end else begin
      if (coef_we) begin
        coef[{word, 1'b0}] <= wdata[COEF_W-1:0];
        coef[{word, 1'b1}] <= wdata[HALF_W +: COEF_W];
      end
      if (quant_we) begin
        quant[{word, 1'b0}] <= wdata[QUANT_W-1:0];
        quant[{word, 1'b1}] <= wdata[HALF_W +: QUANT_W];
      end
    end
  end

  if (QUANT_W < HALF_W) begin : g_spare
    logic unused_quant_bits;
    assign unused_quant_bits = ^{wdata[HALF_W-1:QUANT_W], wdata[31:HALF_W+QUANT_W]};
  end

  for (genvar u = 0; u < BLK; u++) begin : g_dq
    logic signed [DQ_W-1:0] c_ext;
    logic signed [DQ_W-1:0] q_ext;
    assign c_ext     = DQ_W'($signed(coef[{row, BLK_LOG'(u)}]));
    assign q_ext     = DQ_W'({1'b0, quant[{row, BLK_LOG'(u)}]});
    assign row_dq[u] = c_ext * q_ext;
  end

endmodule

// File: rtl/idct_ctrl.sv
module idct_ctrl
  import idct_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_req,
  output logic               busy,
  output logic               done,
  output logic               col_phase,
  output logic [BLK_LOG-1:0] step
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      col_phase <= 1'b0;
      step      <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        col_phase <= 1'b0;
        step      <= '0;
      end
    end else begin
      step <= step + 1'b1;
      if (step == BLK_LOG'(BLK - 1)) begin
        if (col_phase) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          col_phase <= 1'b0;
        end else begin
          col_phase <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/idct_accel.sv
module idct_accel
  import idct_pkg::*;
#(
  parameter int COEF_W   = 16,
  parameter int QUANT_W  = 8,
  parameter int TMP_FRAC = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int CELLS  = BLK * BLK;
  localparam int DQ_W   = COEF_W + QUANT_W + 1;
  localparam int ROW_SH = COS_FRAC + 1 - TMP_FRAC;
  localparam int COL_SH = COS_FRAC + 1 + TMP_FRAC;
  localparam int TMP_W  = DQ_W + BLK_LOG + COS_FRAC + 2 - ROW_SH;
  localparam int ACC_W  = TMP_W + BLK_LOG + COS_FRAC + 1;
  localparam logic [6:0] CTRL_ADDR = 7'h40;

  // ---------------- address decode ----------------
  logic in_coef, in_quant, is_ctrl, in_pix;
  logic busy, done, col_phase;
  logic [BLK_LOG-1:0] step;
  logic coef_we, quant_we, start_req;

  assign in_coef  = (bus_addr[6:5] == 2'b00);
  assign in_quant = (bus_addr[6:5] == 2'b01);
  assign is_ctrl  = (bus_addr == CTRL_ADDR);
  assign in_pix   = (bus_addr[6:4] == 3'b110);

  assign coef_we   = bus_wr && in_coef  && !busy;
  assign quant_we  = bus_wr && in_quant && !busy;
  assign start_req = bus_wr && is_ctrl  && bus_wdata[0];

  // ---------------- submodules ----------------
  logic [BLK-1:0][DQ_W-1:0]  row_dq;
  logic [BLK-1:0][TMP_W-1:0] pass_in;
  logic [BLK-1:0][ACC_W-1:0] pass_out;

  idct_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .busy      (busy),
    .done      (done),
    .col_phase (col_phase),
    .step      (step)
  );

  idct_operand_store #(
    .COEF_W  (COEF_W),
    .QUANT_W (QUANT_W),
    .DQ_W    (DQ_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .coef_we  (coef_we),
    .quant_we (quant_we),
    .word     (bus_addr[2*BLK_LOG-2:0]),
    .wdata    (bus_wdata),
    .row      (step),
    .row_dq   (row_dq)
  );

  idct8_pass #(
    .IN_W  (TMP_W),
    .OUT_W (ACC_W)
  ) u_pass (
    .din  (pass_in),
    .dout (pass_out)
  );

  // ---------------- intermediate and result storage ----------------
  logic [TMP_W-1:0] tmp [CELLS];
  logic [7:0]       pix [CELLS];

  always_comb begin
    for (int i = 0; i < BLK; i++) begin
      if (col_phase) pass_in[i] = tmp[{BLK_LOG'(i), step}];
      else           pass_in[i] = TMP_W'($signed(row_dq[i]));
    end
  end

  function automatic logic [TMP_W-1:0] row_round(input logic [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] t;
    t = $signed(s) + $signed(ACC_W'(1 <<< (ROW_SH - 1)));
    t = t >>> ROW_SH;
    return t[TMP_W-1:0];
  endfunction

  function automatic logic [7:0] to_pixel(input logic [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] t;
    t = $signed(s) + $signed(ACC_W'(1 <<< (COL_SH - 1)));
    t = (t >>> COL_SH) + $signed(ACC_W'(128));
    if (t < 0)        return 8'd0;
    else if (t > 255) return 8'd255;
    else              return t[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (busy && !col_phase) begin
      for (int x = 0; x < BLK; x++) tmp[{step, BLK_LOG'(x)}] <= row_round(pass_out[x]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) pix[i] <= '0;
    end else if (busy && col_phase) begin
      for (int y = 0; y < BLK; y++) pix[{BLK_LOG'(y), step}] <= to_pixel(pass_out[y]);
    end
  end

  // ---------------- read path ----------------
  logic [31:0] pix_word;

  always_comb begin
    for (int j = 0; j < 4; j++) pix_word[8*j +: 8] = pix[{bus_addr[3:0], 2'(j)}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (is_ctrl)     bus_rdata <= {30'd0, busy, done};
      else if (in_pix) bus_rdata <= pix_word;
      else             bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/idct_accel_chk.sv
module idct_accel_chk
  import idct_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [6:0]  bus_addr,
  input logic        start_bit,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic        done
);

  localparam int STEPS = 2 * BLK;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt;
  logic             start_ok;

  assign start_ok = bus_wr && (bus_addr == 7'h40) && start_bit && !busy;

  always_ff @(posedge clk) begin
    if (rst || !busy) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R4
  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (busy && !done));

  // R4
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R5
  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(STEPS)));

  // R5
  a_r5_done_after_count: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && $past(cnt) == CNT_W'(STEPS - 1)));

  // R10
  a_r10_no_early_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CNT_W'(STEPS - 1)) |=> busy);

  // R12
  a_r12_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start_ok) |=> done);

  // R11
  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == 32'd0));

endmodule

bind idct_accel idct_accel_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .start_bit (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .done      (done)
);

// File: tb/idct_accel_tb_top.sv
module idct_accel_tb_top;

  localparam logic [6:0] A_QUANT = 7'h20;
  localparam logic [6:0] A_CTRL  = 7'h40;
  localparam logic [6:0] A_PIX   = 7'h60;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #10 clk = ~clk;

  idct_accel dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cf [64];
  int qt [64];
  int refp [64];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // all bus tasks start and end at a falling edge
  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic real cf_scale(input int u);
    return (u == 0) ? 0.70710678118654 : 1.0;
  endfunction

  task automatic compute_ref();
    for (int y = 0; y < 8; y++) begin
      for (int x = 0; x < 8; x++) begin
        real s;
        int  r;
        s = 0.0;
        for (int v = 0; v < 8; v++)
          for (int u = 0; u < 8; u++)
            s += cf_scale(u) * cf_scale(v) * real'(cf[8*v+u] * qt[8*v+u])
                 * $cos(real'((2*x+1)*u) * PI / 16.0)
                 * $cos(real'((2*y+1)*v) * PI / 16.0);
        s = s / 4.0;
        r = $rtoi($floor(s + 0.5)) + 128;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        refp[8*y+x] = r;
      end
    end
  endtask

  task automatic clear_block();
    for (int i = 0; i < 64; i++) begin cf[i] = 0; qt[i] = 1; end
  endtask

  task automatic load_block();
    for (int k = 0; k < 32; k++) begin
      logic [31:0] w;
      w[15:0]  = cf[2*k][15:0];
      w[31:16] = cf[2*k+1][15:0];
      bus_write(7'(k), w);
    end
    for (int k = 0; k < 32; k++) begin
      logic [31:0] w;
      w = '0;
      w[7:0]   = qt[2*k][7:0];
      w[23:16] = qt[2*k+1][7:0];
      bus_write(A_QUANT + 7'(k), w);
    end
  endtask

  // start and poll; returns the index of the first status read showing done
  task automatic run_op(input string req, output int lat);
    logic [31:0] d;
    bus_write(A_CTRL, 32'd1);
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      bus_read(A_CTRL, d);
      if (k == 1) check(d == 32'd2, "R4", "status after start", int'(d), 2);
      if (d[0]) begin lat = k; break; end
    end
    check(lat == 17, req, "done latency in reads", lat, 17);
  endtask

  task automatic check_block(input string req, input int tol);
    logic [31:0] d;
    for (int k = 0; k < 16; k++) begin
      bus_read(A_PIX + 7'(k), d);
      for (int j = 0; j < 4; j++) begin
        int p, e, df;
        p  = int'(d[8*j +: 8]);
        e  = refp[4*k+j];
        df = p - e;
        check(df <= tol && df >= -tol, req, $sformatf("sample %0d", 4*k+j), p, e);
      end
    end
  endtask

  initial begin
    logic [31:0] d;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(bus_rdata == 32'd0, "R11", "idle rdata", int'(bus_rdata), 0);
    bus_read(A_CTRL, d);
    check(d == 32'd0, "R1", "status after reset", int'(d), 0);
    bus_read(A_PIX + 7'd5, d);
    check(d == 32'd0, "R1", "sample word after reset", int'(d), 0);
    @(negedge clk);
    check(bus_rdata == 32'd0, "R11", "rdata after read ends", int'(bus_rdata), 0);

    // R1/R8: zero coefficients from reset give 128 everywhere
    clear_block();
    compute_ref();
    run_op("R5", lat);
    check_block("R8", 0);

    // R1: quantizer steps reset to 1; DC-only coefficient written alone
    bus_write(7'h00, 32'd80);
    clear_block();
    cf[0] = 80;
    compute_ref();
    run_op("R5", lat);
    check_block("R1", 1);

    // R3: quantizer packing, both halves
    clear_block();
    cf[0] = 10; qt[0] = 8;
    cf[1] = 5;  qt[1] = 7;
    compute_ref();
    load_block();
    run_op("R5", lat);
    check_block("R3", 1);

    // R2/R9: single AC term in upper half of a word, then in a lower half
    clear_block();
    cf[1] = 40;
    compute_ref();
    load_block();
    run_op("R5", lat);
    check_block("R2", 1);
    clear_block();
    cf[8] = -40; cf[19] = 25;
    compute_ref();
    load_block();
    run_op("R5", lat);
    check_block("R9", 1);

    // R7: saturation at both ends, exact
    clear_block();
    cf[0] = 2000;
    compute_ref();
    load_block();
    run_op("R5", lat);
    check_block("R7", 0);
    clear_block();
    cf[0] = -2000;
    compute_ref();
    load_block();
    run_op("R5", lat);
    check_block("R7", 0);

    // R6: random blocks and random quantizer steps
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 64; i++) begin
        qt[i] = int'($urandom_range(1, 6));
        if (i == 0) cf[i] = int'($urandom_range(0, 400)) - 200;
        else if ($urandom_range(0, 3) == 0) cf[i] = int'($urandom_range(0, 60)) - 30;
        else cf[i] = 0;
      end
      compute_ref();
      load_block();
      run_op("R5", lat);
      check_block("R6", 1);
    end

    // R10: writes and restart while busy are ignored
    for (int i = 0; i < 64; i++) begin
      qt[i] = int'($urandom_range(1, 4));
      cf[i] = (i < 10) ? int'($urandom_range(0, 40)) - 20 : 0;
    end
    compute_ref();
    load_block();
    bus_write(A_CTRL, 32'd1);
    bus_write(7'h00, 32'h7fff7fff);
    bus_write(A_QUANT, 32'd0);
    bus_write(A_CTRL, 32'd1);
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      bus_read(A_CTRL, d);
      if (d[0]) begin lat = k; break; end
    end
    check(lat == 14, "R10", "done latency with writes while busy", lat, 14);
    check_block("R10", 1);

    // R12: done holds, operands retained
    bus_read(A_CTRL, d);
    check(d == 32'd1, "R12", "status holds done", int'(d), 1);
    bus_read(A_CTRL, d);
    check(d == 32'd1, "R12", "status still done", int'(d), 1);
    run_op("R12", lat);
    check_block("R12", 1);

    // R11: unmapped reads return 0
    bus_read(7'h50, d);
    check(d == 32'd0, "R11", "unmapped 0x50", int'(d), 0);
    bus_read(7'h41, d);
    check(d == 32'd0, "R11", "unmapped 0x41", int'(d), 0);
    bus_read(7'h00, d);
    check(d == 32'd0, "R11", "coefficient word not readable", int'(d), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule